// File: doc/BRIEF.md
# Dual-Modulus Loop Divider Core

This block holds the digital counting section of one frequency synthesizer loop. A programmable reference divider turns the reference clock into one short pulse every R cycles. A feedback divider counts cycles of an external dual-modulus prescaler's output and gives one pulse every B of those cycles. It also drives the prescaler's modulus line: the prescaler divides by P+1 for the first A cycles of each feedback frame and by P for the rest. The overall feedback ratio seen from the oscillator is therefore N = P*B + A, and the block reports that value for the current settings.

A counter-reset input and a power-down input each hold both dividers in their load state while they are high, and each raises a charge-pump three-state flag. When both inputs drop, the two dividers restart from their load values on the same edge, so the feedback divider starts in step with the reference divider. A settings check flags a main count that is too small or that is less than the swallow count.

Top module: `loop_div_core`

## Requirements
- R1: `ref_pulse` is high for one reference clock every R reference clocks, where R is `ref_div`; an R of 0 divides by 1, the same as an R of 1.
- R2: `fb_pulse` is high for one prescaler clock every B prescaler clocks, where B is `main_cnt` (B of at least 1).
- R3: In each feedback frame `mod_hi` is high for the first A prescaler clocks after the frame starts and low for the rest, where A is `swal_cnt`; with A equal to B it stays high for the whole frame.
- R4: `fb_ratio` equals P*B + A, where `pre_sel` codes 0, 1, 2 and 3 select P = 8, 16, 32 and 64.
- R5: While `cnt_rst` is high both dividers stay in their load state: no output pulses, and `mod_hi` is high exactly when A is non-zero. `cp_hiz` goes high one reference clock after `cnt_rst` or `pwr_dn` rises and low one reference clock after both have fallen.
- R6: While `pwr_dn` is high both dividers are held in their load state in the same way as under `cnt_rst`, with `cp_hiz` high.
- R7: After a hold ends, the first `ref_pulse` follows the R-th reference edge and the first `fb_pulse` follows the B-th prescaler edge, both counted from the first edge with the hold low.
- R8: `cfg_bad` is high exactly when B is below 3 or B is less than A.
- R9: While `rst_n` is low, `ref_pulse`, `fb_pulse` and `mod_hi` are low and `cp_hiz` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock |
| pre_clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_rst | input | 1 | Counter reset hold, active high |
| pwr_dn | input | 1 | Power-down hold, active high |
| ref_div | input | RW (14) | Reference divide value R |
| swal_cnt | input | AW (6) | Swallow count A |
| main_cnt | input | BW (12) | Main count B |
| pre_sel | input | PSW (2) | Prescaler modulus select |
| ref_pulse | output | 1 | Divided reference pulse |
| fb_pulse | output | 1 | Divided feedback pulse |
| mod_hi | output | 1 | Asks the prescaler for modulus P+1 |
| cp_hiz | output | 1 | Charge pump three-state request |
| cfg_bad | output | 1 | Main and swallow counts are not allowed |
| fb_ratio | output | NW (18) | Feedback ratio P*B + A |

## Verification
Directed settings cover the edges of the frame: A of zero (modulus line never high), A equal to B (line high the whole frame), the smallest allowed B of 3, R of 0 and 1 (a pulse on every edge) and a large R against a small B. These tell whether the swallow and main counts run in the right order. Random settings with R and B chosen apart from each other show whether the two dividers keep separate periods while both start from the same release edge. Each run starts with a hold from either counter reset or power-down, and some of these holds begin in the middle of a frame, which shows that both hold sources reload the counters rather than just pausing them.

// File: rtl/loop_div_pkg.sv
package loop_div_pkg;

   // Prescaler modulus for a select code: doubles per code step from 2**min_log2.
   function automatic int unsigned modulus_of(input int unsigned code, input int unsigned min_log2);
      return 32'd1 << (min_log2 + code);
   endfunction

endpackage

// File: rtl/ld_ref_div.sv
module ld_ref_div #(
   parameter int W           = 14,
   parameter bit ZERO_AS_ONE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic [W-1:0] div,
   output logic         pulse
);

   logic [W-1:0] cnt;
   logic [W-1:0] load_val;

   generate
      if (ZERO_AS_ONE) begin : g_zero_one
         assign load_val = (div == '0) ? '0 : div - W'(1);
      end else begin : g_zero_wrap
         assign load_val = div - W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         pulse <= 1'b0;
      end else if (hold) begin
         cnt   <= load_val;
         pulse <= 1'b0;
      end else if (cnt == '0) begin
         cnt   <= load_val;
         pulse <= 1'b1;
      end else begin
         cnt   <= cnt - W'(1);
         pulse <= 1'b0;
      end
   end

endmodule

// File: rtl/ld_swallow_div.sv
module ld_swallow_div #(
   parameter int AW = 6,
   parameter int BW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   input  logic [AW-1:0] a_val,
   input  logic [BW-1:0] b_val,
   output logic          pulse,
   output logic          mod_hi
);

   logic [BW-1:0] b_left;
   logic [AW-1:0] a_left;
   logic [BW-1:0] b_load;

   assign b_load = (b_val == '0) ? '0 : b_val - BW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_left <= '0;
         a_left <= '0;
         pulse  <= 1'b0;
      end else if (hold) begin
         b_left <= b_load;
         a_left <= a_val;
         pulse  <= 1'b0;
      end else if (b_left == '0) begin
         b_left <= b_load;
         a_left <= a_val;
         pulse  <= 1'b1;
      end else begin
         b_left <= b_left - BW'(1);
         a_left <= (a_left != '0) ? a_left - AW'(1) : '0;
         pulse  <= 1'b0;
      end
   end

   // High while swallow cycles remain in the current frame.
   assign mod_hi = (a_left != '0);

endmodule

// File: rtl/ld_modulus_map.sv
module ld_modulus_map
   import loop_div_pkg::*;
#(
   parameter int PSW        = 2,
   parameter int P_MIN_LOG2 = 3,
   parameter int AW         = 6,
   parameter int BW         = 12,
   parameter int NW         = 18
) (
   input  logic [PSW-1:0] sel,
   input  logic [AW-1:0]  a_val,
   input  logic [BW-1:0]  b_val,
   output logic [NW-1:0]  ratio
);

   localparam int NCODES = 2 ** PSW;
   localparam int PW     = P_MIN_LOG2 + NCODES;
   localparam int MW     = PW + BW;

   logic [PW-1:0] tab [NCODES];
   logic [PW-1:0] p_val;
   logic [MW-1:0] prod;

   for (genvar i = 0; i < NCODES; i++) begin : g_tab
      assign tab[i] = PW'(modulus_of(i, P_MIN_LOG2));
   end

   assign p_val = tab[sel];
   assign prod  = MW'(p_val) * MW'(b_val);
   assign ratio = NW'(prod + MW'(a_val));

endmodule

// File: rtl/loop_div_core.sv
module loop_div_core #(
   parameter int RW         = 14,
   parameter int AW         = 6,
   parameter int BW         = 12,
   parameter int PSW        = 2,
   parameter int P_MIN_LOG2 = 3,
   parameter int B_MIN      = 3,
   localparam int NW        = BW + P_MIN_LOG2 + (2 ** PSW) - 1
) (
   input  logic           ref_clk,
   input  logic           pre_clk,
   input  logic           rst_n,
   input  logic           cnt_rst,
   input  logic           pwr_dn,
   input  logic [RW-1:0]  ref_div,
   input  logic [AW-1:0]  swal_cnt,
   input  logic [BW-1:0]  main_cnt,
   input  logic [PSW-1:0] pre_sel,
   output logic           ref_pulse,
   output logic           fb_pulse,
   output logic           mod_hi,
   output logic           cp_hiz,
   output logic           cfg_bad,
   output logic [NW-1:0]  fb_ratio
);

   // Elaboration-time parameter checks
   if (RW < 2) begin : g_err_rw
      $error("loop_div_core: RW must be at least 2");
   end
   if (AW > BW) begin : g_err_aw
      $error("loop_div_core: AW must not exceed BW");
   end
   if (AW > NW - BW) begin : g_err_nw
      $error("loop_div_core: swallow count too wide for ratio output");
   end
   if (B_MIN >= 2 ** BW) begin : g_err_bmin
      $error("loop_div_core: B_MIN out of range");
   end

   logic hold;
   assign hold = cnt_rst | pwr_dn;

   ld_ref_div #(
      .W           (RW),
      .ZERO_AS_ONE (1'b1)
   ) u_ref (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .hold  (hold),
      .div   (ref_div),
      .pulse (ref_pulse)
   );

   ld_swallow_div #(
      .AW (AW),
      .BW (BW)
   ) u_fb (
      .clk    (pre_clk),
      .rst_n  (rst_n),
      .hold   (hold),
      .a_val  (swal_cnt),
      .b_val  (main_cnt),
      .pulse  (fb_pulse),
      .mod_hi (mod_hi)
   );

   ld_modulus_map #(
      .PSW        (PSW),
      .P_MIN_LOG2 (P_MIN_LOG2),
      .AW         (AW),
      .BW         (BW),
      .NW         (NW)
   ) u_map (
      .sel   (pre_sel),
      .a_val (swal_cnt),
      .b_val (main_cnt),
      .ratio (fb_ratio)
   );

   assign cfg_bad = (main_cnt < BW'(B_MIN)) || (main_cnt < BW'(swal_cnt));

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) cp_hiz <= 1'b1;
      else        cp_hiz <= hold;
   end

endmodule

// File: rtl/loop_div_core_chk.sv
module loop_div_core_chk #(
   parameter int RW = 14,
   parameter int AW = 6,
   parameter int BW = 12
) (
   input logic          ref_clk,
   input logic          pre_clk,
   input logic          rst_n,
   input logic          cnt_rst,
   input logic          pwr_dn,
   input logic [RW-1:0] ref_div,
   input logic [AW-1:0] swal_cnt,
   input logic [BW-1:0] main_cnt,
   input logic          ref_pulse,
   input logic          fb_pulse,
   input logic          mod_hi,
   input logic          cp_hiz
);

   // R1
   ref_pulse_width_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (ref_pulse && ref_div > RW'(1) && $stable(ref_div)) |=> !ref_pulse);

   // R2
   fb_pulse_width_chk: assert property (@(posedge pre_clk) disable iff (!rst_n)
      (fb_pulse && main_cnt > BW'(1) && $stable(main_cnt)) |=> !fb_pulse);

   // R3
   frame_start_mod_chk: assert property (@(posedge pre_clk) disable iff (!rst_n)
      (fb_pulse && $stable(swal_cnt)) |-> (mod_hi == (swal_cnt != '0)));

   // R5
   hold_ref_quiet_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (cnt_rst || pwr_dn) |=> !ref_pulse);

   // R6
   hold_fb_quiet_chk: assert property (@(posedge pre_clk) disable iff (!rst_n)
      (cnt_rst || pwr_dn) |=> !fb_pulse);

   // R5
   hold_hiz_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (cnt_rst || pwr_dn) |=> cp_hiz);

endmodule

bind loop_div_core loop_div_core_chk #(
   .RW (RW),
   .AW (AW),
   .BW (BW)
) u_chk (
   .ref_clk   (ref_clk),
   .pre_clk   (pre_clk),
   .rst_n     (rst_n),
   .cnt_rst   (cnt_rst),
   .pwr_dn    (pwr_dn),
   .ref_div   (ref_div),
   .swal_cnt  (swal_cnt),
   .main_cnt  (main_cnt),
   .ref_pulse (ref_pulse),
   .fb_pulse  (fb_pulse),
   .mod_hi    (mod_hi),
   .cp_hiz    (cp_hiz)
);

// File: tb/loop_div_core_test.sv
`timescale 1ns/1ps
module loop_div_core_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cnt_rst;
   logic        pwr_dn;
   logic [13:0] ref_div;
   logic [5:0]  swal_cnt;
   logic [11:0] main_cnt;
   logic [1:0]  pre_sel;
   logic        ref_pulse;
   logic        fb_pulse;
   logic        mod_hi;
   logic        cp_hiz;
   logic        cfg_bad;
   logic [17:0] fb_ratio;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   loop_div_core uut (
      .ref_clk   (clk),
      .pre_clk   (clk),
      .rst_n     (rst_n),
      .cnt_rst   (cnt_rst),
      .pwr_dn    (pwr_dn),
      .ref_div   (ref_div),
      .swal_cnt  (swal_cnt),
      .main_cnt  (main_cnt),
      .pre_sel   (pre_sel),
      .ref_pulse (ref_pulse),
      .fb_pulse  (fb_pulse),
      .mod_hi    (mod_hi),
      .cp_hiz    (cp_hiz),
      .cfg_bad   (cfg_bad),
      .fb_ratio  (fb_ratio)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint exp_ratio(input int sel, input int a, input int b);
      return longint'((8 << sel) * b + a);
   endfunction

   function automatic bit exp_bad(input int a, input int b);
      return (b < 3) || (b < a);
   endfunction

   task automatic run_trial(input int r, input int a, input int b, input int sel,
                            input bit use_pd, input int ncyc);
      int re;
      @(negedge clk);
      if (use_pd) pwr_dn = 1'b1; else cnt_rst = 1'b1;
      ref_div  = 14'(r);
      swal_cnt = 6'(a);
      main_cnt = 12'(b);
      pre_sel  = 2'(sel);
      repeat (3) @(negedge clk);
      chk(use_pd ? "R6 cp_hiz in power-down" : "R5 cp_hiz in counter reset", longint'(cp_hiz), 1);
      chk(use_pd ? "R6 ref_pulse held" : "R5 ref_pulse held", longint'(ref_pulse), 0);
      chk(use_pd ? "R6 fb_pulse held" : "R5 fb_pulse held", longint'(fb_pulse), 0);
      chk("R5 mod_hi in load state", longint'(mod_hi), longint'(a > 0));
      chk("R4 fb_ratio", longint'(fb_ratio), exp_ratio(sel, a, b));
      chk("R8 cfg_bad", longint'(cfg_bad), longint'(exp_bad(a, b)));
      re = (r == 0) ? 1 : r;
      cnt_rst = 1'b0;
      pwr_dn  = 1'b0;
      for (int k = 1; k <= ncyc; k++) begin
         @(negedge clk);
         // R7: counting starts at the first edge after release
         chk("R1 R7 ref_pulse", longint'(ref_pulse), longint'((k % re) == 0));
         chk("R2 R7 fb_pulse", longint'(fb_pulse), longint'((k % b) == 0));
         chk("R3 mod_hi", longint'(mod_hi), longint'((k % b) < a));
         if (k == 1) chk("R5 cp_hiz release", longint'(cp_hiz), 0);
      end
   endtask

   task automatic flag_only(input int a, input int b);
      swal_cnt = 6'(a);
      main_cnt = 12'(b);
      #1;
      chk("R8 cfg_bad directed", longint'(cfg_bad), longint'(exp_bad(a, b)));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int r, a, b, sel, mx;
      void'($urandom(32'd4711));
      rst_n    = 1'b0;
      cnt_rst  = 1'b1;
      pwr_dn   = 1'b0;
      ref_div  = 14'd4;
      swal_cnt = 6'd2;
      main_cnt = 12'd5;
      pre_sel  = 2'd0;
      repeat (2) @(negedge clk);
      chk("R9 ref_pulse in reset", longint'(ref_pulse), 0);
      chk("R9 fb_pulse in reset", longint'(fb_pulse), 0);
      chk("R9 mod_hi in reset", longint'(mod_hi), 0);
      chk("R9 cp_hiz in reset", longint'(cp_hiz), 1);
      rst_n = 1'b1;
      cnt_rst = 1'b0;

      // Directed corner cases
      run_trial(4, 2, 5, 0, 1'b0, 30);
      run_trial(0, 0, 3, 1, 1'b0, 12);
      run_trial(1, 3, 3, 2, 1'b1, 12);
      run_trial(7, 63, 63, 3, 1'b1, 140);
      run_trial(300, 5, 10, 1, 1'b0, 320);
      run_trial(6, 1, 6, 0, 1'b1, 40);

      // R8 flag corners while held
      @(negedge clk);
      cnt_rst = 1'b1;
      flag_only(0, 2);
      flag_only(10, 5);
      flag_only(3, 3);
      flag_only(0, 0);
      flag_only(63, 4095);

      // Constrained random settings, some released mid-frame
      for (int t = 0; t < 20; t++) begin
         r   = 1 + int'($urandom_range(49));
         b   = 3 + int'($urandom_range(47));
         a   = int'($urandom_range(b > 63 ? 63 : b));
         sel = int'($urandom_range(3));
         mx  = (r > b) ? r : b;
         run_trial(r, a, b, sel, t[0], 2 * mx + int'($urandom_range(mx)) + 3);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule